// File: doc/BRIEF.md
# Weight-Stationary Matrix Tile Sequencer

This block runs one tile of a matrix product C = A x B on a grid of multiply-accumulate cells and sequences the whole operation from a single start pulse. The host first hands over the RED_LEN rows of B, one row of N_COLS weights per accepted beat, and the block keeps them resident. It then takes the RED_LEN columns of A, one column of N_ROWS activations per accepted beat. These are skewed into the grid so that every cell meets the matching activation and weight on the same step.

Once the last column is in, the controller runs the grid on its own until the skew has emptied. It then offers the N_ROWS rows of C one at a time on a valid/ready output. Nothing is buffered at the output. The grid advances only when an activation beat or a result beat is accepted, so a slow consumer stalls the grid and loses nothing. `busy_o` covers the whole operation. A one-cycle `done_o` follows the last result beat.

Top module: `sa_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, `busy_o`, `done_o`, `wgt_ready_o`, `act_ready_o` and `res_valid_o` are low. A reset in the middle of an operation abandons it, and the next start runs normally.
- R2: A `start_i` pulse while idle raises `busy_o` on the next cycle. `busy_o` stays high up to and including the cycle in which `done_o` is high, and is low on the cycle after.
- R3: `start_i` is ignored while `busy_o` is high, including the `done_o` cycle. The running operation completes unchanged and no second operation begins.
- R4: Weight beats come first. `wgt_ready_o` is high only until RED_LEN beats with `wgt_valid_i` and `wgt_ready_o` both high have been taken. Beat k carries row k of B, with column n at bits [n*WGT_W +: WGT_W].
- R5: Activation beats follow the weight phase. `act_ready_o` is high only until RED_LEN accepted beats. Beat k carries column k of A, with row m at bits [m*ACT_W +: ACT_W].
- R6: Cycles with a low `wgt_valid_i` or `act_valid_i` transfer nothing and do not advance the beat count.
- R7: Result beat m carries row m of C, with rows in increasing m and column n at bits [n*ACC_W +: ACC_W]. Element (m,n) equals the sum over k of A[m][k]*B[k][n], in two's complement when SIGNED_MUL is 1.
- R8: `res_valid_o` first goes high N_ROWS+N_COLS-1 cycles after the cycle that holds the final activation handshake.
- R9: While `res_valid_o` is high and `res_ready_i` is low, `res_valid_o` and `res_row_o` hold their values on the next cycle.
- R10: `done_o` is high for exactly one cycle per operation: the cycle after the final result handshake.
- R11: At most one of `wgt_ready_o`, `act_ready_o`, `res_valid_o` and `done_o` is high in any cycle.
- R12: Each operation starts from cleared accumulators. Results of an operation do not depend on the data of the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one tile operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wgt_row_i | input | N_COLS*WGT_W | One row of B |
| wgt_valid_i | input | 1 | Weight row valid |
| wgt_ready_o | output | 1 | Weight row accepted when valid |
| act_col_i | input | N_ROWS*ACT_W | One column of A |
| act_valid_i | input | 1 | Activation column valid |
| act_ready_o | output | 1 | Activation column accepted when valid |
| res_row_o | output | N_COLS*ACC_W | One row of C |
| res_valid_o | output | 1 | Result row valid |
| res_ready_i | input | 1 | Consumer takes the result row |

## Verification
Gaps in both valid inputs and a stuttering `res_ready_i` target the stall path. A design that advanced the grid or the beat counter on idle cycles would misalign the skew and corrupt the sums, and one that shifted results without a handshake would drop rows. Operand extremes of -128 and 127 expose a multiplier that drops the sign extension. A start pulse during activation streaming and on the done cycle catches a controller that restarts while busy. Back-to-back operations and a reset in the middle of weight loading catch accumulators or counters that are not cleared. The exact gap from the last activation beat to the first valid result pins down the flush count.

// File: rtl/sa_seq_pkg.sv
package sa_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_W,
    ST_STREAM_A,
    ST_DRAIN,
    ST_DONE
  } sa_state_e;

endpackage

// File: rtl/sa_wgt_bank.sv
module sa_wgt_bank #(
  parameter int N_COLS  = 4,
  parameter int RED_LEN = 4,
  parameter int WGT_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [N_COLS*WGT_W-1:0]   wrow_i,
  output logic [N_COLS*WGT_W-1:0]   rrow_o
);

  localparam int ROW_W = N_COLS * WGT_W;

  logic [ROW_W-1:0] mem_q [RED_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RED_LEN; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < RED_LEN; i++)
        if (idx_i == IDX_W'(i)) mem_q[i] <= wrow_i;
    end
  end

  always_comb begin
    rrow_o = '0;
    for (int i = 0; i < RED_LEN; i++)
      if (idx_i == IDX_W'(i)) rrow_o = mem_q[i];
  end

endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 8,
  parameter int ACC_W      = 32,
  parameter bit SIGNED_MUL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic [ACT_W-1:0] a_i,
  input  logic [WGT_W-1:0] w_i,
  input  logic [ACC_W-1:0] acc_in_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam int PROD_W = ACT_W + WGT_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] acc_q;

  generate
    if (SIGNED_MUL) begin : g_signed
      logic signed [PROD_W-1:0] prod_s;
      assign prod_s   = $signed(a_i) * $signed(w_i);
      assign prod_ext = {{EXT_W{prod_s[PROD_W-1]}}, prod_s};
    end else begin : g_unsigned
      logic [PROD_W-1:0] prod_u;
      assign prod_u   = a_i * w_i;
      assign prod_ext = {{EXT_W{1'b0}}, prod_u};
    end
  endgenerate

  // shift (result drain) and step (compute) never coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (shift_i) acc_q <= acc_in_i;
    else if (step_i)  acc_q <= acc_q + prod_ext;
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/sa_grid.sv
module sa_grid #(
  parameter int N_ROWS     = 4,
  parameter int N_COLS     = 4,
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 8,
  parameter int ACC_W      = 32,
  parameter bit SIGNED_MUL = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     step_i,
  input  logic                     clr_i,
  input  logic                     shift_i,
  input  logic [N_ROWS*ACT_W-1:0]  a_edge_i,
  input  logic [N_COLS*WGT_W-1:0]  w_edge_i,
  output logic [N_COLS*ACC_W-1:0]  res_row_o
);

  logic [ACT_W-1:0] a_in   [N_ROWS][N_COLS];
  logic [WGT_W-1:0] w_in   [N_ROWS][N_COLS];
  logic [ACC_W-1:0] acc    [N_ROWS][N_COLS];
  logic [ACC_W-1:0] acc_up [N_ROWS][N_COLS];

  // row r enters r steps late
  generate
    for (genvar r = 0; r < N_ROWS; r++) begin : g_askew
      if (r == 0) begin : g_direct
        assign a_in[r][0] = a_edge_i[r*ACT_W +: ACT_W];
      end else begin : g_delay
        logic [ACT_W-1:0] sk_q [r];
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            for (int i = 0; i < r; i++) sk_q[i] <= '0;
          end else if (clr_i) begin
            for (int i = 0; i < r; i++) sk_q[i] <= '0;
          end else if (step_i) begin
            sk_q[0] <= a_edge_i[r*ACT_W +: ACT_W];
            for (int i = 1; i < r; i++) sk_q[i] <= sk_q[i-1];
          end
        end
        assign a_in[r][0] = sk_q[r-1];
      end
    end

    // column c enters c steps late
    for (genvar c = 0; c < N_COLS; c++) begin : g_wskew
      if (c == 0) begin : g_direct
        assign w_in[0][c] = w_edge_i[c*WGT_W +: WGT_W];
      end else begin : g_delay
        logic [WGT_W-1:0] sk_q [c];
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            for (int i = 0; i < c; i++) sk_q[i] <= '0;
          end else if (clr_i) begin
            for (int i = 0; i < c; i++) sk_q[i] <= '0;
          end else if (step_i) begin
            sk_q[0] <= w_edge_i[c*WGT_W +: WGT_W];
            for (int i = 1; i < c; i++) sk_q[i] <= sk_q[i-1];
          end
        end
        assign w_in[0][c] = sk_q[c-1];
      end
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      for (genvar c = 0; c < N_COLS; c++) begin : g_col
        if (c < N_COLS - 1) begin : g_apass
          logic [ACT_W-1:0] a_q;
          always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     a_q <= '0;
            else if (clr_i)  a_q <= '0;
            else if (step_i) a_q <= a_in[r][c];
          end
          assign a_in[r][c+1] = a_q;
        end
        if (r < N_ROWS - 1) begin : g_wpass
          logic [WGT_W-1:0] w_q;
          always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)     w_q <= '0;
            else if (clr_i)  w_q <= '0;
            else if (step_i) w_q <= w_in[r][c];
          end
          assign w_in[r+1][c] = w_q;
          assign acc_up[r][c] = acc[r+1][c];
        end else begin : g_bottom
          assign acc_up[r][c] = '0;
        end

        sa_pe #(
          .ACT_W      (ACT_W),
          .WGT_W      (WGT_W),
          .ACC_W      (ACC_W),
          .SIGNED_MUL (SIGNED_MUL)
        ) u_pe (
          .clk_i    (clk_i),
          .rst_ni   (rst_ni),
          .step_i   (step_i),
          .clr_i    (clr_i),
          .shift_i  (shift_i),
          .a_i      (a_in[r][c]),
          .w_i      (w_in[r][c]),
          .acc_in_i (acc_up[r][c]),
          .acc_o    (acc[r][c])
        );
      end
    end

    for (genvar c = 0; c < N_COLS; c++) begin : g_out
      assign res_row_o[c*ACC_W +: ACC_W] = acc[0][c];
    end
  endgenerate

endmodule

// File: rtl/sa_seq_ctrl.sv
module sa_seq_ctrl
  import sa_seq_pkg::*;
#(
  parameter int N_ROWS     = 4,
  parameter int N_COLS     = 4,
  parameter int RED_LEN    = 4,
  parameter int ACT_W      = 8,
  parameter int WGT_W      = 8,
  parameter int ACC_W      = 32,
  parameter bit SIGNED_MUL = 1'b1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  output logic                     busy_o,
  output logic                     done_o,
  input  logic [N_COLS*WGT_W-1:0]  wgt_row_i,
  input  logic                     wgt_valid_i,
  output logic                     wgt_ready_o,
  input  logic [N_ROWS*ACT_W-1:0]  act_col_i,
  input  logic                     act_valid_i,
  output logic                     act_ready_o,
  output logic [N_COLS*ACC_W-1:0]  res_row_o,
  output logic                     res_valid_o,
  input  logic                     res_ready_i
);

  localparam int FLUSH     = N_ROWS + N_COLS - 2;
  localparam int DRAIN_END = FLUSH + N_ROWS;
  localparam int CNT_MAX   = (RED_LEN > DRAIN_END) ? RED_LEN : DRAIN_END;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  sa_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic w_hs, a_hs, r_hs, in_flush, step, clr;
  logic [N_COLS*WGT_W-1:0] bank_row, w_edge;
  logic [N_ROWS*ACT_W-1:0] a_edge;

  assign wgt_ready_o = (state_q == ST_LOAD_W);
  assign act_ready_o = (state_q == ST_STREAM_A);
  assign in_flush    = (state_q == ST_DRAIN) && (cnt_q < CNT_W'(FLUSH));
  assign res_valid_o = (state_q == ST_DRAIN) && !in_flush;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);

  assign w_hs = wgt_valid_i && wgt_ready_o;
  assign a_hs = act_valid_i && act_ready_o;
  assign r_hs = res_valid_o && res_ready_i;

  // grid moves only on accepted activations or while emptying the skew
  assign step   = a_hs || in_flush;
  assign clr    = (state_q == ST_IDLE) && start_i;
  assign a_edge = act_ready_o ? act_col_i : '0;
  assign w_edge = act_ready_o ? bank_row  : '0;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_LOAD_W;
          cnt_d   = '0;
        end
      end
      ST_LOAD_W: begin
        if (w_hs) begin
          if (cnt_q == CNT_W'(RED_LEN - 1)) begin
            state_d = ST_STREAM_A;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_STREAM_A: begin
        if (a_hs) begin
          if (cnt_q == CNT_W'(RED_LEN - 1)) begin
            state_d = ST_DRAIN;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DRAIN: begin
        if (in_flush) begin
          cnt_d = cnt_q + 1'b1;
        end else if (r_hs) begin
          if (cnt_q == CNT_W'(DRAIN_END - 1)) begin
            state_d = ST_DONE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  sa_wgt_bank #(
    .N_COLS  (N_COLS),
    .RED_LEN (RED_LEN),
    .WGT_W   (WGT_W),
    .IDX_W   (CNT_W)
  ) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (w_hs),
    .idx_i  (cnt_q),
    .wrow_i (wgt_row_i),
    .rrow_o (bank_row)
  );

  sa_grid #(
    .N_ROWS     (N_ROWS),
    .N_COLS     (N_COLS),
    .ACT_W      (ACT_W),
    .WGT_W      (WGT_W),
    .ACC_W      (ACC_W),
    .SIGNED_MUL (SIGNED_MUL)
  ) u_grid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .clr_i     (clr),
    .shift_i   (r_hs),
    .a_edge_i  (a_edge),
    .w_edge_i  (w_edge),
    .res_row_o (res_row_o)
  );

endmodule

// File: rtl/sa_seq_ctrl_chk.sv
module sa_seq_ctrl_chk #(
  parameter int N_COLS = 4,
  parameter int ACC_W  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic                    wgt_ready_o,
  input logic                    act_ready_o,
  input logic [N_COLS*ACC_W-1:0] res_row_o,
  input logic                    res_valid_o,
  input logic                    res_ready_i
);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(wgt_ready_o || act_ready_o || res_valid_o || done_o));

  p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_busy_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

  p_stream_after_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_ready_o) |-> $past(wgt_ready_o));

  p_res_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_row_o)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_one_phase_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wgt_ready_o, act_ready_o, res_valid_o, done_o}));

endmodule

bind sa_seq_ctrl sa_seq_ctrl_chk #(
  .N_COLS (N_COLS),
  .ACC_W  (ACC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .wgt_ready_o (wgt_ready_o),
  .act_ready_o (act_ready_o),
  .res_row_o   (res_row_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i)
);

// File: tb/tb_sa_seq_ctrl.sv
module tb_sa_seq_ctrl;

  localparam int NR = 4;
  localparam int NC = 4;
  localparam int KD = 4;
  localparam int AW = 8;
  localparam int WW = 8;
  localparam int CW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o;
  logic [NC*WW-1:0] wgt_row_i = '0;
  logic wgt_valid_i = 1'b0;
  logic wgt_ready_o;
  logic [NR*AW-1:0] act_col_i = '0;
  logic act_valid_i = 1'b0;
  logic act_ready_o;
  logic [NC*CW-1:0] res_row_o;
  logic res_valid_o;
  logic res_ready_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int ma [NR][KD];
  int mb [KD][NC];

  always #10 clk_i = ~clk_i;

  sa_seq_ctrl #(
    .N_ROWS (NR), .N_COLS (NC), .RED_LEN (KD),
    .ACT_W (AW), .WGT_W (WW), .ACC_W (CW), .SIGNED_MUL (1'b1)
  ) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i),
    .busy_o (busy_o), .done_o (done_o),
    .wgt_row_i (wgt_row_i), .wgt_valid_i (wgt_valid_i), .wgt_ready_o (wgt_ready_o),
    .act_col_i (act_col_i), .act_valid_i (act_valid_i), .act_ready_o (act_ready_o),
    .res_row_o (res_row_o), .res_valid_o (res_valid_o), .res_ready_i (res_ready_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit pat(input int gap, input int cyc);
    return (gap == 0) || ((cyc % gap) != 0);
  endfunction

  function automatic int exp_c(input int m, input int n);
    int s = 0;
    for (int k = 0; k < KD; k++) s += ma[m][k] * mb[k][n];
    return s;
  endfunction

  task automatic fill(input int seed);
    for (int m = 0; m < NR; m++)
      for (int k = 0; k < KD; k++) ma[m][k] = ((m*5 + k*3 + seed*7) % 19) - 9;
    for (int k = 0; k < KD; k++)
      for (int n = 0; n < NC; n++) mb[k][n] = ((k*11 + n*2 + seed*3) % 23) - 11;
  endtask

  function automatic bit idle_outs();
    return !busy_o && !done_o && !wgt_ready_o && !act_ready_o && !res_valid_o;
  endfunction

  // one full operation; data gaps set by vgap, consumer stalls by rgap
  task automatic run_op(input int vgap, input int rgap, input bit extra_start, input string tag);
    int wi = 0, ai = 0, ri = 0, n_done = 0;
    int last_act = -1, first_val = -1, last_res = -1, done_cyc = -1;
    int order_err = 0, hold_err = 0, busy_err = 0;
    bit prev_stall = 0;
    logic [NC*CW-1:0] held = '0;
    @(negedge clk_i);
    start_i = 1'b1;
    for (int cyc = 1; cyc < 3000; cyc++) begin
      @(negedge clk_i);
      if (cyc == 1) chk(busy_o === 1'b1, "R2", {tag, " busy after start"}, busy_o, 1);
      if (prev_stall && (!res_valid_o || res_row_o !== held)) hold_err++;
      if (n_done > 0 && !done_o) begin
        chk(busy_o === 1'b0, "R2", {tag, " busy after done"}, busy_o, 0);
        chk(n_done == 1, "R10", {tag, " done pulse count"}, n_done, 1);
        break;
      end
      if (done_o) begin
        n_done++;
        done_cyc = cyc;
        chk(done_cyc == last_res + 1, "R10", {tag, " done cycle"}, done_cyc, last_res + 1);
        chk(ri == NR, "R7", {tag, " rows before done"}, ri, NR);
      end
      if (!busy_o) busy_err++;
      if (act_ready_o && wi < KD) order_err++;
      if (wgt_ready_o && wi >= KD) order_err++;
      if (act_ready_o && ai >= KD) order_err++;
      if (res_valid_o && ai < KD) order_err++;
      // drive next beat
      start_i = extra_start && (cyc == 3 || done_o);
      wgt_valid_i = (wi < KD) && pat(vgap, cyc);
      if (wi < KD) for (int n = 0; n < NC; n++) wgt_row_i[n*WW +: WW] = WW'(mb[wi][n]);
      if (wgt_valid_i && wgt_ready_o) wi++;
      act_valid_i = (ai < KD) && pat(vgap, cyc + 1);
      if (ai < KD) for (int m = 0; m < NR; m++) act_col_i[m*AW +: AW] = AW'(ma[m][ai]);
      if (act_valid_i && act_ready_o) begin
        ai++;
        if (ai == KD) last_act = cyc;
      end
      res_ready_i = pat(rgap, cyc + 1);
      if (res_valid_o) begin
        if (first_val < 0) first_val = cyc;
        if (res_ready_i && ri < NR) begin
          for (int n = 0; n < NC; n++)
            chk(res_row_o[n*CW +: CW] === CW'(exp_c(ri, n)), "R7",
                $sformatf("%s C[%0d][%0d]", tag, ri, n),
                longint'($signed(res_row_o[n*CW +: CW])), exp_c(ri, n));
          last_res = cyc;
          ri++;
        end
      end
      prev_stall = res_valid_o && !res_ready_i;
      held = res_row_o;
    end
    start_i = 1'b0; wgt_valid_i = 1'b0; act_valid_i = 1'b0; res_ready_i = 1'b0;
    chk(n_done == 1, "R3", {tag, " exactly one completion"}, n_done, 1);
    chk(wi == KD, "R4", {tag, " weight beats"}, wi, KD);
    chk(ai == KD, "R5", {tag, " activation beats"}, ai, KD);
    chk(order_err == 0, "R11", {tag, " phase order violations"}, order_err, 0);
    chk(busy_err == 0, "R2", {tag, " busy dropped early"}, busy_err, 0);
    chk(hold_err == 0, "R9", {tag, " stalled row changed"}, hold_err, 0);
    chk(first_val - last_act == NR + NC - 1, "R8", {tag, " result latency"},
        first_val - last_act, NR + NC - 1);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(idle_outs(), "R1", "outputs in reset", {busy_o, done_o, wgt_ready_o, act_ready_o, res_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(idle_outs(), "R1", "outputs after reset", {busy_o, done_o, wgt_ready_o, act_ready_o, res_valid_o}, 0);
  endtask

  task automatic t_basic();
    fill(1);
    run_op(0, 0, 1'b0, "basic R4 R5 R7");
  endtask

  task automatic t_stalls();
    fill(2);
    run_op(3, 2, 1'b0, "gaps R6 R9");
  endtask

  task automatic t_signed_extremes();
    for (int m = 0; m < NR; m++)
      for (int k = 0; k < KD; k++) ma[m][k] = ((m + k) % 2 == 0) ? -128 : 127;
    for (int k = 0; k < KD; k++)
      for (int n = 0; n < NC; n++) mb[k][n] = (n == 0) ? -128 : ((k % 2 == 0) ? 127 : -1);
    run_op(0, 3, 1'b0, "signed R7");
  endtask

  task automatic t_start_busy();
    fill(3);
    run_op(2, 0, 1'b1, "start while busy R3");
    repeat (2) @(negedge clk_i);
    chk(!busy_o, "R3", "no restart after done", busy_o, 0);
  endtask

  task automatic t_back_to_back();
    fill(4);
    run_op(0, 0, 1'b0, "first of pair R12");
    fill(5);
    run_op(0, 0, 1'b0, "second of pair R12");
  endtask

  task automatic t_reset_mid();
    fill(6);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wgt_valid_i = 1'b1;
    repeat (2) @(negedge clk_i);
    wgt_valid_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(idle_outs(), "R1", "mid-operation reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(idle_outs(), "R1", "after mid-operation reset", busy_o, 0);
    run_op(0, 0, 1'b0, "after reset R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (R10): actual=hung expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_stalls();
    t_signed_extremes();
    t_start_busy();
    t_back_to_back();
    t_reset_mid();
    repeat (3) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule